// File: doc/BRIEF.md
# Flash Write-Status Polling Logic

This block produces the byte a flash device returns on a read while it runs an internal program or erase, and for a short time after. Software starts a program (with the byte to store) or an erase. It then polls the read bus to learn when the operation has finished. While busy, bit 7 carries the inverse of the expected final value, and bit 6 changes on every read. Once the operation completes, bit 7 shows its true value at once. The lower bits become trustworthy only after a settle window.

A down-counter stands in for the operation time. A second counter, sized from the clock frequency, models the settle window. A `data_valid` output marks when the whole byte holds stored data. Reads with an invalid address return no status. The stored byte is a single register: a program leaves the written byte in it and an erase leaves 0xFF in it.

Top module: `flash_poll_status`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `data_valid` is 1 with `addr_valid` high, `rd_data` is 0xFF, and the toggle bit is 0.
- R2: While a program runs, `rd_data[7]` is the inverse of bit 7 of the written byte, `rd_data[5:0]` is 0 and `data_valid` is 0. `busy` stays high for PROG_CYCLES cycles after the edge that accepts the request.
- R3: After an operation and its settle window, `rd_data` equals the stored byte (the written byte after a program, 0xFF after an erase) and `data_valid` is 1.
- R4: While an erase runs, `rd_data[7]` is 0 for ERASE_CYCLES cycles. Once it completes, `rd_data[7]` reads 1.
- R5: While busy, `rd_data[6]` shows the toggle bit. The toggle bit inverts after each cycle that has `rd_stb` and `addr_valid` both high. It holds in cycles without such a read, and it holds once the operation is finished.
- R6: For SETTLE_CYCLES = ceil(CLK_MHZ*SETTLE_NS/1000) cycles after `busy` falls, `rd_data[7]` is the true bit, `rd_data[6]` is the frozen toggle bit, `rd_data[5:0]` is 0 and `data_valid` is 0.
- R7: With `addr_valid` low, `rd_data` is 0x00 and `data_valid` is 0. Such a read does not advance the toggle bit.
- R8: A program or erase request while `busy` is high is ignored. A request during the settle window is accepted.
- R9: The toggle bit is cleared to 0 when a new operation is accepted.
- R10: If program and erase are requested in the same idle cycle, the program is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_start | input | 1 | Request to program `prog_byte` |
| prog_byte | input | 8 | Byte to program |
| erase_start | input | 1 | Request to erase |
| rd_stb | input | 1 | Read strobe for the current cycle |
| addr_valid | input | 1 | Read address lies in the valid range |
| rd_data | output | 8 | Read data / status byte |
| data_valid | output | 1 | All eight bits of `rd_data` are stored data |
| busy | output | 1 | Internal operation in progress |

## Verification
A wrong operation counter shows as `busy` falling early or late. It also shows as the polarity of bit 7 flipping in the wrong cycle, which the bench sees on the first read at that cycle. A toggle register that is not cleared or advanced correctly shows as a wrong bit 6 on the next busy read. An error in the settle counter shows as `data_valid` rising in the wrong cycle, or as the low bits coming out of zero too early. Every cycle is compared against a bench model, so a divergence is reported in the cycle where it first reaches the ports.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_kind_e;

    typedef struct packed {
        op_kind_e    kind;
        logic [7:0]  wbyte;
    } op_req_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    function automatic int unsigned settle_cycles(int unsigned mhz, int unsigned ns);
        return (mhz * ns + 999) / 1000;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // status byte seen while an operation is running
    function automatic logic [7:0] busy_status(op_kind_e kind, logic [7:0] wbyte, logic tog);
        logic b7;
        b7 = (kind == OP_PROG) ? ~wbyte[7] : 1'b0;
        return {b7, tog, 6'b0};
    endfunction

    // status byte seen during the settle window
    function automatic logic [7:0] settle_status(logic [7:0] stored, logic tog);
        return {stored[7], tog, 6'b0};
    endfunction

endpackage

// File: rtl/fps_req_arbiter.sv
module fps_req_arbiter
    import flash_poll_pkg::*;
(
    input  logic       prog_start,
    input  logic       erase_start,
    input  logic [7:0] prog_byte,
    input  logic       busy,
    output logic       accept,
    output op_req_t    req
);
    always_comb begin
        req.wbyte = prog_byte;
        if (prog_start)       req.kind = OP_PROG;
        else if (erase_start) req.kind = OP_ERASE;
        else                  req.kind = OP_NONE;
        accept = !busy && (prog_start || erase_start);
    end
endmodule

// File: rtl/fps_down_counter.sv
module fps_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         clr,
    input  logic [W-1:0] load_val,
    output logic         active,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (clr)           cnt_q <= '0;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q == W'(1));
endmodule

// File: rtl/fps_toggle.sv
module fps_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic tog
);
    always_ff @(posedge clk) begin
        if (rst)      tog <= 1'b0;
        else if (clr) tog <= 1'b0;
        else if (adv) tog <= ~tog;
    end
endmodule

// File: rtl/fps_read_mux.sv
module fps_read_mux
    import flash_poll_pkg::*;
(
    input  logic       addr_valid,
    input  logic       busy,
    input  logic       settling,
    input  op_kind_e   kind,
    input  logic [7:0] wbyte,
    input  logic [7:0] stored,
    input  logic       tog,
    output logic [7:0] rd_data,
    output logic       data_valid
);
    always_comb begin
        if (!addr_valid) begin
            rd_data    = 8'h00;
            data_valid = 1'b0;
        end else if (busy) begin
            rd_data    = busy_status(kind, wbyte, tog);
            data_valid = 1'b0;
        end else if (settling) begin
            rd_data    = settle_status(stored, tog);
            data_valid = 1'b0;
        end else begin
            rd_data    = stored;
            data_valid = 1'b1;
        end
    end
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
    import flash_poll_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 100,
    parameter int unsigned SETTLE_NS    = 1000,
    parameter int unsigned PROG_CYCLES  = 20,
    parameter int unsigned ERASE_CYCLES = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       prog_start,
    input  logic [7:0] prog_byte,
    input  logic       erase_start,
    input  logic       rd_stb,
    input  logic       addr_valid,
    output logic [7:0] rd_data,
    output logic       data_valid,
    output logic       busy
);
    localparam int unsigned SETTLE_CYC = settle_cycles(CLK_MHZ, SETTLE_NS);
    localparam int unsigned OP_MAX     = max_u(PROG_CYCLES, ERASE_CYCLES);
    localparam int          OPW        = $clog2(OP_MAX + 1);
    localparam int          SW         = (SETTLE_CYC > 0) ? $clog2(SETTLE_CYC + 1) : 1;

    logic       accept;
    op_req_t    req;
    logic       op_done;
    logic       settling;
    logic       settle_last;
    logic       tog_q;
    op_kind_e   kind_q;
    logic [7:0] wbyte_q;
    logic [7:0] stored_q;
    logic [OPW-1:0] op_len;

    fps_req_arbiter u_arb (
        .prog_start  (prog_start),
        .erase_start (erase_start),
        .prog_byte   (prog_byte),
        .busy        (busy),
        .accept      (accept),
        .req         (req)
    );

    assign op_len = (req.kind == OP_PROG) ? OPW'(PROG_CYCLES) : OPW'(ERASE_CYCLES);

    fps_down_counter #(.W(OPW)) u_op_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .clr      (1'b0),
        .load_val (op_len),
        .active   (busy),
        .last     (op_done)
    );

    fps_down_counter #(.W(SW)) u_settle_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (op_done),
        .clr      (accept),
        .load_val (SW'(SETTLE_CYC)),
        .active   (settling),
        .last     (settle_last)
    );

    fps_toggle u_tog (
        .clk (clk),
        .rst (rst),
        .clr (accept),
        .adv (busy && rd_stb && addr_valid),
        .tog (tog_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q   <= OP_NONE;
            wbyte_q  <= 8'h00;
            stored_q <= ERASED_BYTE;
        end else begin
            if (accept) begin
                kind_q  <= req.kind;
                wbyte_q <= req.wbyte;
            end
            if (op_done)
                stored_q <= (kind_q == OP_PROG) ? wbyte_q : ERASED_BYTE;
        end
    end

    fps_read_mux u_mux (
        .addr_valid (addr_valid),
        .busy       (busy),
        .settling   (settling),
        .kind       (kind_q),
        .wbyte      (wbyte_q),
        .stored     (stored_q),
        .tog        (tog_q),
        .rd_data    (rd_data),
        .data_valid (data_valid)
    );

    logic unused_ok;
    assign unused_ok = settle_last;
endmodule

// File: rtl/flash_poll_status_chk.sv
module flash_poll_status_chk
    import flash_poll_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       prog_start,
    input logic       rd_stb,
    input logic       addr_valid,
    input logic [7:0] rd_data,
    input logic       data_valid,
    input logic       busy,
    input logic       accept,
    input logic       op_done,
    input logic       tog,
    input op_kind_e   kind,
    input logic [7:0] wbyte
);
    AST_BUSY_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
        busy |-> !data_valid); // R2
    AST_PROG_POLL: assert property (@(posedge clk) disable iff (rst)
        (busy && kind == OP_PROG && addr_valid) |-> (rd_data[7] != wbyte[7])); // R2
    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (rst)
        (busy && kind == OP_ERASE && addr_valid) |-> !rd_data[7]); // R4
    AST_ERASE_DONE: assert property (@(posedge clk) disable iff (rst)
        (op_done && kind == OP_ERASE) |=> (!addr_valid || rd_data[7])); // R4
    AST_TOG_FLIP: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_stb && addr_valid) |=> (tog != $past(tog))); // R5
    AST_TOG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !accept) |=> $stable(tog)); // R5
    AST_BAD_ADDR: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |-> (rd_data == 8'h00 && !data_valid)); // R7
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(kind) && $stable(wbyte))); // R8
    AST_TOG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        accept |=> !tog); // R9
    AST_PROG_FIRST: assert property (@(posedge clk) disable iff (rst)
        (accept && prog_start) |=> (kind == OP_PROG)); // R10
endmodule

bind flash_poll_status flash_poll_status_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .prog_start (prog_start),
    .rd_stb     (rd_stb),
    .addr_valid (addr_valid),
    .rd_data    (rd_data),
    .data_valid (data_valid),
    .busy       (busy),
    .accept     (accept),
    .op_done    (op_done),
    .tog        (tog_q),
    .kind       (kind_q),
    .wbyte      (wbyte_q)
);

// File: tb/flash_poll_status_tb.sv
`timescale 1ns/1ps
module flash_poll_status_tb;
    localparam int PROG_C   = 20;
    localparam int ERASE_C  = 60;
    localparam int SETTLE_C = 100;   // ceil(100 MHz * 1000 ns / 1000)

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_start = 1'b0;
    logic [7:0] prog_byte = 8'h00;
    logic       erase_start = 1'b0;
    logic       rd_stb = 1'b0;
    logic       addr_valid = 1'b1;
    logic [7:0] rd_data;
    logic       data_valid;
    logic       busy;

    int checks = 0;
    int errors = 0;

    // bench model state
    int         m_op = 0;       // 1 program, 2 erase
    int         m_opcnt = 0;
    int         m_settle = 0;
    logic       m_tog = 1'b0;
    logic [7:0] m_wbyte = 8'h00;
    logic [7:0] m_stored = 8'hFF;

    always #5 clk = ~clk;

    flash_poll_status u_dut (
        .clk(clk), .rst(rst), .prog_start(prog_start), .prog_byte(prog_byte),
        .erase_start(erase_start), .rd_stb(rd_stb), .addr_valid(addr_valid),
        .rd_data(rd_data), .data_valid(data_valid), .busy(busy)
    );

    function automatic logic [8:0] exp_out(logic av);
        if (!av)               return 9'h000;
        if (m_opcnt != 0)      return {1'b0, (m_op == 1) ? ~m_wbyte[7] : 1'b0, m_tog, 6'b0};
        if (m_settle != 0)     return {1'b0, m_stored[7], m_tog, 6'b0};
        return {1'b1, m_stored};
    endfunction

    function automatic string auto_tag(logic p, logic e, logic av);
        if (!av)                        return "R7";
        if (m_opcnt != 0 && (p || e))   return "R8";
        if (m_opcnt != 0)               return (m_op == 1) ? "R2/R5" : "R4/R5";
        if (m_settle != 0)              return "R6";
        return "R3";
    endfunction

    task automatic step(input logic p, input logic e, input logic [7:0] d,
                        input logic rd, input logic av, input string tag);
        logic [8:0] ex;
        string t;
        logic acc, mb;
        @(negedge clk);
        prog_start = p; erase_start = e; prog_byte = d; rd_stb = rd; addr_valid = av;
        #1;
        ex = exp_out(av);
        t  = (tag == "") ? auto_tag(p, e, av) : tag;
        checks++;
        if ({data_valid, rd_data} !== ex || busy !== (m_opcnt != 0)) begin
            errors++;
            $display("FAIL %s: rd_data=%h valid=%b busy=%b expected rd_data=%h valid=%b busy=%b",
                     t, rd_data, data_valid, busy, ex[7:0], ex[8], (m_opcnt != 0));
        end
        @(posedge clk);
        mb  = (m_opcnt != 0);
        acc = !mb && (p || e);
        if (mb && rd && av) m_tog = ~m_tog;
        if (acc) begin
            m_op = p ? 1 : 2;
            m_wbyte = d;
            m_opcnt = p ? PROG_C : ERASE_C;
            m_tog = 1'b0;
            m_settle = 0;
        end else if (mb) begin
            if (m_opcnt == 1) begin
                m_stored = (m_op == 1) ? m_wbyte : 8'hFF;
                m_settle = SETTLE_C;
            end
            m_opcnt--;
        end else if (m_settle != 0) begin
            m_settle--;
        end
    endtask

    task automatic idle_reads(input int n, input logic rd);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, rd, 1'b1, "");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1: watchdog expired actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R1");
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R1");

        // R2 program with bit7 low, read every cycle
        step(1'b1, 1'b0, 8'h5A, 1'b0, 1'b1, "R2");
        idle_reads(PROG_C + SETTLE_C + 4, 1'b1);

        // R2/R5 program with bit7 high, reads every other cycle
        step(1'b1, 1'b0, 8'hC3, 1'b0, 1'b1, "R2");
        for (int i = 0; i < PROG_C + 4; i++) step(1'b0, 1'b0, 8'h00, i[0], 1'b1, "");
        // R9: restart during settle with toggle possibly set, then expect toggle 0
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R6");
        step(1'b1, 1'b0, 8'h11, 1'b0, 1'b1, "R8");
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R9");
        idle_reads(PROG_C + SETTLE_C + 2, 1'b1);

        // R4 erase with program requests while busy (R8)
        step(1'b0, 1'b1, 8'h00, 1'b1, 1'b1, "R4");
        for (int i = 0; i < ERASE_C; i++)
            step((i % 7) == 3, (i % 11) == 5, 8'h00, 1'b1, (i % 5) != 2, "");
        idle_reads(SETTLE_C + 3, 1'b0);

        // R10 simultaneous requests
        step(1'b1, 1'b1, 8'h3C, 1'b0, 1'b1, "R10");
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R10");
        idle_reads(PROG_C + SETTLE_C + 2, 1'b0);

        // R7 invalid address reads during busy do not advance toggle
        step(1'b1, 1'b0, 8'h80, 1'b1, 1'b0, "R7");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R5");
        idle_reads(PROG_C + SETTLE_C, 1'b1);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic p, e, rd, av;
            logic [7:0] d;
            p  = ($urandom % 100) < 3;
            e  = ($urandom % 100) < 2;
            rd = ($urandom % 100) < 60;
            av = ($urandom % 100) < 85;
            d  = 8'($urandom);
            step(p, e, d, rd, av, "");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule